// File: doc/BRIEF.md
# Atomic Memory Port with Reservations

A small word-addressed memory shared by several requesters. Each requester presents one operation at a time: a plain load, a plain store, an indivisible swap, a load-linked, or a store-conditional. A round-robin arbiter grants one requester per cycle. The whole read-modify-write of the granted operation takes place at a single clock edge, so a swap can never interleave with another access. This makes a swap returning 0 a safe way to take a lock, where 0 means free and 1 means taken.

Each requester owns one reservation register. The register holds a valid flag and the address of that requester's most recent load-linked. Any completed write to that address by a different requester clears the reservation. A store-conditional writes memory only while its own reservation is valid and matches the address. It reports 1 on success and 0 on failure, and it consumes the reservation in either case.

Top module: `amp_port`

## Requirements
- R1: A load (op code 0) returns the addressed word on `rsp_data_o`. It does so in the cycle after its grant, with the bit of that requester set in `rsp_valid_o`. Requester i uses slice [i*W +: W] of each packed request bus. Op codes 5 to 7 behave as a load.
- R2: A store (op code 1) writes `wdata` to the addressed word and responds with data 0.
- R3: A swap (op code 2) responds with the old word and leaves the new value in memory. Both happen as one indivisible step.
- R4: A load-linked (op code 3) returns the addressed word and sets that requester's reservation on the address.
- R5: A store-conditional (op code 4) succeeds only if its requester holds a valid reservation on exactly that address. On success it writes and responds 1; on failure it writes nothing and responds 0.
- R6: A store, a swap or a successful store-conditional clears the reservation of every other requester reserved on the same address. Writes to other addresses, and the requester's own writes, leave reservations intact.
- R7: A store-conditional clears its own requester's reservation, whether it succeeds or fails.
- R8: At most one grant is given per cycle, and only to a requesting port. A grant is always given when any port requests. Priority rotates to the port after the last one granted, and port 0 has first priority after reset.
- R9: Reset zeroes memory, invalidates all reservations, and suppresses grants and responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request strobe per requester, held until granted |
| req_op_i | input | 3*N_REQ | Operation code per requester |
| req_addr_i | input | ADDR_W*N_REQ | Word address per requester |
| req_wdata_i | input | DATA_W*N_REQ | Write or swap value per requester |
| req_gnt_o | output | N_REQ | One-hot grant, same cycle as the request |
| rsp_valid_o | output | N_REQ | Response strobe, one cycle after the grant |
| rsp_data_o | output | DATA_W | Old word, store-conditional flag, or 0 |

## Verification
The assertions check the arbiter on every cycle. They confirm that grants are one-hot and go only to requesting ports, that no request is left idle, that no port is granted twice in a row while another waits, and that a response follows each grant. They also check that every store-conditional leaves its own reservation cleared. Only the bench scenarios can show the data-side behaviour: swap values, whether a store-conditional succeeds after another port's store or swap, and that a write to an unrelated address leaves a reservation alone. The same holds for memory and reservation contents after reset.

// File: rtl/amp_pkg.sv
package amp_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_LL    = 3'd3,
    OP_SC    = 3'd4
  } op_e;
endpackage

// File: rtl/amp_arb.sv
module amp_arb #(
  parameter int N_REQ = 3,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] valid_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < N_REQ; k++) begin
      int c;
      c = (int'(last_q) + 1 + k) % N_REQ;
      if (!any_o && valid_i[c]) begin
        any_o    = 1'b1;
        idx_o    = IDX_W'(c);
        gnt_o[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IDX_W'(N_REQ - 1);
    else if (any_o) last_q <= idx_o;
  end
endmodule

// File: rtl/amp_resv.sv
module amp_resv
  import amp_pkg::*;
#(
  parameter int N_REQ  = 3,
  parameter int ADDR_W = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              sc_ok_o,
  output logic [N_REQ-1:0]  vld_o
);
  logic [N_REQ-1:0]             vld_q;
  logic [N_REQ-1:0][ADDR_W-1:0] addr_q;

  assign sc_ok_o = vld_q[idx_i] && (addr_q[idx_i] == addr_i);
  assign vld_o   = vld_q;

  for (genvar j = 0; j < N_REQ; j++) begin : g_slot
    logic own;
    assign own = fire_i && (idx_i == IDX_W'(j));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[j]  <= 1'b0;
        addr_q[j] <= '0;
      end else if (own && op_i == OP_LL) begin
        vld_q[j]  <= 1'b1;
        addr_q[j] <= addr_i;
      end else if (own && op_i == OP_SC) begin
        vld_q[j]  <= 1'b0;
      end else if (!own && we_i && addr_q[j] == addr_i) begin
        vld_q[j]  <= 1'b0;  // foreign write kills the link
      end
    end
  end
endmodule

// File: rtl/amp_mem.sv
module amp_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/amp_port.sv
module amp_port
  import amp_pkg::*;
#(
  parameter int N_REQ  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_REQ-1:0]          req_valid_i,
  input  logic [3*N_REQ-1:0]        req_op_i,
  input  logic [ADDR_W*N_REQ-1:0]   req_addr_i,
  input  logic [DATA_W*N_REQ-1:0]   req_wdata_i,
  output logic [N_REQ-1:0]          req_gnt_o,
  output logic [N_REQ-1:0]          rsp_valid_o,
  output logic [DATA_W-1:0]         rsp_data_o
);
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [IDX_W-1:0]  g_idx;
  logic              g_any, sc_ok, mem_we, sc_fire;
  logic [N_REQ-1:0]  resv_vld;
  op_e               g_op;
  logic [ADDR_W-1:0] g_addr;
  logic [DATA_W-1:0] g_wdata, rdata;
  logic [N_REQ-1:0]  rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  amp_arb #(.N_REQ(N_REQ)) u_arb (
    .clk_i, .rst_ni,
    .valid_i(req_valid_i & {N_REQ{rst_ni}}),
    .gnt_o(req_gnt_o), .idx_o(g_idx), .any_o(g_any)
  );

  always_comb begin
    logic [2:0] raw;
    raw = req_op_i[g_idx*3 +: 3];
    g_op = (raw > 3'd4) ? OP_LOAD : op_e'(raw);
  end
  assign g_addr  = req_addr_i[g_idx*ADDR_W +: ADDR_W];
  assign g_wdata = req_wdata_i[g_idx*DATA_W +: DATA_W];
  assign sc_fire = g_any && (g_op == OP_SC);
  assign mem_we  = g_any && ((g_op == OP_STORE) || (g_op == OP_SWAP) ||
                             (g_op == OP_SC && sc_ok));

  amp_resv #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) u_resv (
    .clk_i, .rst_ni, .fire_i(g_any), .idx_i(g_idx), .op_i(g_op),
    .addr_i(g_addr), .we_i(mem_we), .sc_ok_o(sc_ok), .vld_o(resv_vld)
  );

  amp_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni, .addr_i(g_addr), .we_i(mem_we),
    .wdata_i(g_wdata), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= req_gnt_o;
      if (g_any) begin
        unique case (g_op)
          OP_STORE: rsp_data_q <= '0;
          OP_SC:    rsp_data_q <= DATA_W'(sc_ok);
          default:  rsp_data_q <= rdata;
        endcase
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/amp_port_chk.sv
module amp_port_chk #(
  parameter int N_REQ = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] valid_i,
  input logic [N_REQ-1:0] gnt_i,
  input logic [N_REQ-1:0] rsp_valid_i,
  input logic             sc_fire_i,
  input logic [N_REQ-1:0] resv_vld_i
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i)); // R8
  AST_GNT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i & ~valid_i) == '0); // R8
  AST_NO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_i) |-> (|gnt_i)); // R8
  AST_RR_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gnt_i & $past(gnt_i))) |-> ($past(valid_i & ~gnt_i) == '0)); // R8
  AST_RSP_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_i) |=> (rsp_valid_i == $past(gnt_i))); // R1
  AST_SC_DROPS_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_fire_i |=> ((resv_vld_i & $past(gnt_i)) == '0)); // R7
endmodule

bind amp_port amp_port_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(req_valid_i), .gnt_i(req_gnt_o),
  .rsp_valid_i(rsp_valid_o), .sc_fire_i(sc_fire), .resv_vld_i(resv_vld)
);

// File: tb/amp_port_tb.sv
module amp_port_tb;
  localparam int N = 3, AW = 4, DW = 8;
  localparam time HALF = 2.5ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]    valid = '0;
  logic [3*N-1:0]  op = '0;
  logic [AW*N-1:0] addr = '0;
  logic [DW*N-1:0] wdata = '0;
  logic [N-1:0]    gnt, rsp_valid;
  logic [DW-1:0]   rsp_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #HALF clk = ~clk;

  amp_port #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_op_i(op),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_gnt_o(gnt),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  // {tag 4, req 2, op 3, addr 4, wdata 8, expected 8}
  localparam int NV = 30;
  localparam logic [28:0] VEC [NV] = '{
    {4'd1, 2'd0, 3'd0, 4'h3, 8'h00, 8'h00}, // R1 load of reset memory
    {4'd2, 2'd0, 3'd1, 4'h3, 8'h5A, 8'h00}, // R2 store
    {4'd2, 2'd1, 3'd0, 4'h3, 8'h00, 8'h5A}, // R2 visible to another port
    {4'd3, 2'd1, 3'd2, 4'h3, 8'h01, 8'h5A}, // R3 swap returns old
    {4'd3, 2'd2, 3'd2, 4'h3, 8'h01, 8'h01}, // R3 lock already held
    {4'd4, 2'd0, 3'd3, 4'h5, 8'h00, 8'h00}, // R4 link
    {4'd5, 2'd0, 3'd4, 4'h5, 8'h07, 8'h01}, // R5 sc succeeds
    {4'd5, 2'd0, 3'd0, 4'h5, 8'h00, 8'h07}, // R5 value written
    {4'd7, 2'd0, 3'd4, 4'h5, 8'h09, 8'h00}, // R7 link consumed
    {4'd7, 2'd0, 3'd0, 4'h5, 8'h00, 8'h07}, // R7 nothing written
    {4'd4, 2'd1, 3'd3, 4'h5, 8'h00, 8'h07}, // R4
    {4'd6, 2'd2, 3'd1, 4'h5, 8'h02, 8'h00}, // R6 foreign store
    {4'd6, 2'd1, 3'd4, 4'h5, 8'h08, 8'h00}, // R6 sc fails
    {4'd6, 2'd1, 3'd0, 4'h5, 8'h00, 8'h02}, // R6 no write
    {4'd4, 2'd1, 3'd3, 4'h6, 8'h00, 8'h00}, // R4
    {4'd6, 2'd2, 3'd1, 4'h7, 8'h03, 8'h00}, // R6 other address
    {4'd6, 2'd1, 3'd4, 4'h6, 8'h04, 8'h01}, // R6 link survives
    {4'd4, 2'd2, 3'd3, 4'h8, 8'h00, 8'h00}, // R4
    {4'd6, 2'd2, 3'd2, 4'h8, 8'h00, 8'h00}, // R6 own swap
    {4'd6, 2'd2, 3'd4, 4'h8, 8'h06, 8'h01}, // R6 own write keeps link
    {4'd6, 2'd2, 3'd0, 4'h8, 8'h00, 8'h06}, // R6
    {4'd4, 2'd2, 3'd3, 4'h9, 8'h00, 8'h00}, // R4
    {4'd6, 2'd0, 3'd2, 4'h9, 8'h01, 8'h00}, // R6 foreign swap
    {4'd6, 2'd2, 3'd4, 4'h9, 8'h05, 8'h00}, // R6 sc fails
    {4'd6, 2'd2, 3'd0, 4'h9, 8'h00, 8'h01}, // R6
    {4'd4, 2'd0, 3'd3, 4'hA, 8'h00, 8'h00}, // R4
    {4'd5, 2'd0, 3'd4, 4'hB, 8'h03, 8'h00}, // R5 address mismatch
    {4'd5, 2'd0, 3'd0, 4'hB, 8'h00, 8'h00}, // R5 no write
    {4'd5, 2'd0, 3'd0, 4'h6, 8'h00, 8'h04}, // R5 earlier success landed
    {4'd1, 2'd1, 3'd7, 4'h7, 8'h00, 8'h03}  // R1 spare code as load
  };

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(int r, logic [2:0] o, logic [AW-1:0] a,
                       logic [DW-1:0] wd, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    valid = '0;
    valid[r] = 1'b1;
    op[r*3 +: 3] = o;
    addr[r*AW +: AW] = a;
    wdata[r*DW +: DW] = wd;
    #1;
    chk(gnt == N'(1 << r), {tag, " grant"}, 32'(gnt), 32'(1 << r));
    @(negedge clk);
    valid = '0;
    chk(rsp_valid == N'(1 << r), {tag, " rsp_valid"}, 32'(rsp_valid), 32'(1 << r));
    chk(rsp_data == exp, {tag, " data"}, 32'(rsp_data), 32'(exp));
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == '0 && gnt == '0, "R9 reset outputs", 32'(rsp_valid), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VEC[v];
      do_op(int'(e[24:23]), e[22:20], e[19:16], e[15:8], e[7:0],
            $sformatf("R%0d vec%0d", e[28:25], v));
    end

    // R9: reset drops memory and reservations
    do_op(0, 3'd3, 4'h4, 8'h00, 8'h00, "R9 link before reset");
    @(negedge clk);
    rst_n = 1'b0;
    valid = 3'b111;
    #1;
    chk(gnt == '0, "R9 no grant in reset", 32'(gnt), 0);
    @(negedge clk);
    chk(rsp_valid == '0, "R9 no rsp in reset", 32'(rsp_valid), 0);
    valid = '0;
    rst_n = 1'b1;
    do_op(0, 3'd0, 4'h3, 8'h00, 8'h00, "R9 memory cleared");
    do_op(0, 3'd4, 4'h4, 8'h0F, 8'h00, "R9 link cleared");

    // R8: contention after another reset, port 0 first
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < N; r++) begin
      op[r*3 +: 3] = 3'd0;
      addr[r*AW +: AW] = 4'h0;
    end
    valid = 3'b111;
    for (int r = 0; r < N; r++) begin
      #1;
      chk(gnt == N'(1 << r), "R8 rotation", 32'(gnt), 32'(1 << r));
      @(negedge clk);
      valid[r] = 1'b0;
    end
    valid = 3'b101;
    #1;
    chk(gnt == 3'b001, "R8 wrap to port 0", 32'(gnt), 1);
    @(negedge clk);
    #1;
    chk(gnt == 3'b100, "R8 waiting port served", 32'(gnt), 4);
    @(negedge clk);
    valid = '0;
    chk(rsp_valid == 3'b100, "R8 rsp follows", 32'(rsp_valid), 4);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule